// File: doc/BRIEF.md
# Dual Byte Counter with Mode-Dependent Direction

This block holds two event counters that advance on single-cycle count pulses. The first counter is one byte wide. The second is built from a low byte and a high byte. With cascading off, the second counter is an 8-bit counter and its high byte holds its value. With cascading on, the two bytes act as one 16-bit counter: the high byte takes a step each time the low byte passes through its boundary.

A two-bit mode input sets the counting direction:

- **Normal mode:** both counters count up.
- **Pointer-tracking mode:** a per-counter direction input, sampled with each pulse, chooses increment or decrement.
- **Remote-control mode:** the second counter counts down.

Prescaling and quadrature decoding take place upstream. This block only receives the pulses that result from them.

Software reaches every byte through a byte-wide register port. The port has a write strobe with a byte select, and a separate combinational read select. Each counter has a wrap flag that goes high for exactly one cycle when the counter wraps.

Top module: `tmr_counter_pair`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is asserted, all three counter bytes and both wrap flags are zero.
- R2: Counter A steps by one per `cnt_a_pulse`, modulo 256. The mode encoding is 0 = normal, 1 = pointer-tracking, 2 = remote-control, and 3 = treated as normal. In mode 1, `dir_a` = 1 increments and `dir_a` = 0 decrements. In every other mode counter A increments whatever the value of `dir_a`.
- R3: The low byte of counter B steps by one per `cnt_b_pulse`, modulo 256. In mode 1 it follows `dir_b` (1 = up, 0 = down). In mode 2 it decrements. In modes 0 and 3 it increments.
- R4: When `casc_en` = 0, the high byte of counter B keeps its value through any count activity and changes only through a register write.
- R5: A write with `wr_sel` = 0, 1 or 2 loads `wr_data` into counter A, the low byte of counter B or the high byte of counter B, respectively. A write with `wr_sel` = 3 changes nothing. `rd_data` combinationally shows the byte picked by `rd_sel` (same encoding), and reads 0 when `rd_sel` = 3.
- R6: When a write and a count step target the same byte in the same cycle, the written value wins and that byte does not step.
- R7: A wrap flag is high for exactly the one cycle that follows a step across the counter's boundary (0xFF to 0x00 going up, or 0x00 to 0xFF going down).
  - `wrap_a` covers counter A.
  - `wrap_b` covers counter B at the 8-bit boundary when `casc_en` = 0, and at the 16-bit boundary when `casc_en` = 1.
- R8: When `casc_en` = 1, the high byte of counter B steps only when the low byte wraps, and it moves in the same direction as the low byte did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode (0 normal, 1 pointer-tracking, 2 remote-control, 3 normal) |
| casc_en | input | 1 | Joins the two B bytes into one 16-bit counter |
| cnt_a_pulse | input | 1 | Count pulse for counter A |
| dir_a | input | 1 | Direction for counter A in mode 1 (1 = up) |
| cnt_b_pulse | input | 1 | Count pulse for counter B |
| dir_b | input | 1 | Direction for counter B in mode 1 (1 = up) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Byte targeted by the write |
| wr_data | input | BYTE_W | Write data |
| rd_sel | input | 2 | Byte shown on rd_data |
| rd_data | output | BYTE_W | Selected byte |
| cnt_a | output | BYTE_W | Counter A value |
| cnt_b | output | 2*BYTE_W | Counter B value, high byte in the upper half |
| wrap_a | output | 1 | One-cycle wrap flag for counter A |
| wrap_b | output | 1 | One-cycle wrap flag for counter B |

## Verification
Each counter byte is registered and driven straight to a port, so a wrong direction decode or a missed step shows up as a wrong value on `cnt_a` or `cnt_b` one cycle after the pulse. A fault in the cascade carry is different. It stays hidden until the low byte reaches its boundary, which can take up to 256 pulses. For that reason the tests preload the boundary values through the register port. A wrap flag that is wrongly held high, or never raised, is visible in the cycle right after the boundary step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_TRACK  = 2'd1,
        MODE_REMOTE = 2'd2,
        MODE_SPARE  = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_BLO = 2'd1,
        SEL_BHI = 2'd2,
        SEL_NONE = 2'd3
    } sel_t;

    localparam int NUM_BYTES = 3;
    localparam int IDX_A   = 0;
    localparam int IDX_BLO = 1;
    localparam int IDX_BHI = 2;

endpackage

// File: rtl/tmr_dir_dec.sv
module tmr_dir_dec
    import tmr_pkg::*;
#(
    parameter bit DOWN_IN_REMOTE = 1'b0
) (
    input  mode_t mode,
    input  logic  dir,
    output logic  up
);
    always_comb begin
        unique case (mode)
            MODE_TRACK:  up = dir;
            MODE_REMOTE: up = ~DOWN_IN_REMOTE;
            default:     up = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_byte_step.sv
module tmr_byte_step #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         up,
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt  = val;
        wrap = 1'b0;
        if (en) begin
            if (up) begin
                nxt  = val + ONE;
                wrap = (val == '1);
            end else begin
                nxt  = val - ONE;
                wrap = (val == '0);
            end
        end
    end
endmodule

// File: rtl/tmr_counter_pair.sv
module tmr_counter_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic                  casc_en,
    input  logic                  cnt_a_pulse,
    input  logic                  dir_a,
    input  logic                  cnt_b_pulse,
    input  logic                  dir_b,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic [1:0]            rd_sel,
    output logic [BYTE_W-1:0]     rd_data,
    output logic [BYTE_W-1:0]     cnt_a,
    output logic [2*BYTE_W-1:0]   cnt_b,
    output logic                  wrap_a,
    output logic                  wrap_b
);
    localparam int WIDE_W = 2 * BYTE_W;

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
        logic                             wa;
        logic                             wb;
    } state_t;

    state_t st_d, st_q;

    mode_t mode_e;
    assign mode_e = mode_t'(mode);

    logic up_a, up_b;

    tmr_dir_dec #(.DOWN_IN_REMOTE(1'b0)) u_dir_a (
        .mode (mode_e),
        .dir  (dir_a),
        .up   (up_a)
    );

    tmr_dir_dec #(.DOWN_IN_REMOTE(1'b1)) u_dir_b (
        .mode (mode_e),
        .dir  (dir_b),
        .up   (up_b)
    );

    logic [NUM_BYTES-1:0]             wr_hit;
    logic [NUM_BYTES-1:0]             step_en;
    logic [NUM_BYTES-1:0]             step_up;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] step_nxt;
    logic [NUM_BYTES-1:0]             step_wrap;

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            wr_hit[i] = wr_en && (wr_sel == 2'(i));
        end
    end

    logic blo_wrapped;
    assign blo_wrapped = step_wrap[IDX_BLO] & ~wr_hit[IDX_BLO];

    assign step_en[IDX_A]   = cnt_a_pulse;
    assign step_en[IDX_BLO] = cnt_b_pulse;
    assign step_en[IDX_BHI] = casc_en & blo_wrapped;
    assign step_up[IDX_A]   = up_a;
    assign step_up[IDX_BLO] = up_b;
    assign step_up[IDX_BHI] = up_b;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_step
        tmr_byte_step #(.W(BYTE_W)) u_step (
            .en   (step_en[g]),
            .up   (step_up[g]),
            .val  (st_q.bytes[g]),
            .nxt  (step_nxt[g]),
            .wrap (step_wrap[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.wa = 1'b0;
        st_d.wb = 1'b0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_hit[i]) begin
                st_d.bytes[i] = wr_data;
            end else begin
                st_d.bytes[i] = step_nxt[i];
            end
        end
        st_d.wa = step_wrap[IDX_A] & ~wr_hit[IDX_A];
        if (casc_en) begin
            st_d.wb = blo_wrapped & step_wrap[IDX_BHI] & ~wr_hit[IDX_BHI];
        end else begin
            st_d.wb = blo_wrapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel_t'(rd_sel))
            SEL_A:   rd_data = st_q.bytes[IDX_A];
            SEL_BLO: rd_data = st_q.bytes[IDX_BLO];
            SEL_BHI: rd_data = st_q.bytes[IDX_BHI];
            default: rd_data = '0;
        endcase
    end

    assign cnt_a  = st_q.bytes[IDX_A];
    assign cnt_b  = WIDE_W'({st_q.bytes[IDX_BHI], st_q.bytes[IDX_BLO]});
    assign wrap_a = st_q.wa;
    assign wrap_b = st_q.wb;

endmodule

// File: rtl/tmr_counter_pair_chk.sv
module tmr_counter_pair_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode,
    input logic                casc_en,
    input logic                cnt_a_pulse,
    input logic                cnt_b_pulse,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [BYTE_W-1:0]   wr_data,
    input logic [1:0]          rd_sel,
    input logic [BYTE_W-1:0]   rd_data,
    input logic [BYTE_W-1:0]   cnt_a,
    input logic [2*BYTE_W-1:0] cnt_b,
    input logic                wrap_a
);
    localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

    logic [BYTE_W-1:0] b_lo, b_hi;
    assign b_lo = cnt_b[BYTE_W-1:0];
    assign b_hi = cnt_b[2*BYTE_W-1:BYTE_W];

    AST_A_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (cnt_a == $past(wr_data))); // R6

    AST_A_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a_pulse && mode != 2'd1 && !(wr_en && wr_sel == 2'd0))
        |=> (cnt_a == $past(cnt_a) + ONE)); // R2

    AST_BLO_REMOTE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_b_pulse && mode == 2'd2 && !(wr_en && wr_sel == 2'd1))
        |=> (b_lo == $past(b_lo) - ONE)); // R3

    AST_BHI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc_en && !(wr_en && wr_sel == 2'd2)) |=> $stable(b_hi)); // R4

    AST_WRAP_A_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_a |-> ((cnt_a == '0 && $past(cnt_a) == '1) ||
                    (cnt_a == '1 && $past(cnt_a) == '0))); // R7

    AST_RD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data == '0)); // R5

endmodule

bind tmr_counter_pair tmr_counter_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .casc_en     (casc_en),
    .cnt_a_pulse (cnt_a_pulse),
    .cnt_b_pulse (cnt_b_pulse),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .cnt_a       (cnt_a),
    .cnt_b       (cnt_b),
    .wrap_a      (wrap_a)
);

// File: tb/tmr_counter_pair_bench.sv
`timescale 1ns/1ps
module tmr_counter_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        casc_en, cnt_a_pulse, dir_a, cnt_b_pulse, dir_b, wr_en;
    logic [1:0]  wr_sel, rd_sel;
    logic [7:0]  wr_data, rd_data, cnt_a;
    logic [15:0] cnt_b;
    logic        wrap_a, wrap_b;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_counter_pair u_tmr_counter_pair (
        .clk(clk), .rst_n(rst_n), .mode(mode), .casc_en(casc_en),
        .cnt_a_pulse(cnt_a_pulse), .dir_a(dir_a), .cnt_b_pulse(cnt_b_pulse),
        .dir_b(dir_b), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .wrap_a(wrap_a), .wrap_b(wrap_b)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_a(input logic d);
        cnt_a_pulse = 1'b1; dir_a = d;
        step();
        cnt_a_pulse = 1'b0;
    endtask

    task automatic pulse_b(input logic d);
        cnt_b_pulse = 1'b1; dir_b = d;
        step();
        cnt_b_pulse = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #1;
        check("R1", "cnt_a in reset", 16'(cnt_a), 16'h0);
        check("R1", "cnt_b in reset", cnt_b, 16'h0);
        check("R1", "flags in reset", {14'b0, wrap_a, wrap_b}, 16'h0);
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_regs();
        wr(2'd0, 8'h3C); wr(2'd1, 8'hA5); wr(2'd2, 8'h5A);
        rd_sel = 2'd0; #0.1 check("R5", "read A", 16'(rd_data), 16'h3C);
        rd_sel = 2'd1; #0.1 check("R5", "read B low", 16'(rd_data), 16'hA5);
        rd_sel = 2'd2; #0.1 check("R5", "read B high", 16'(rd_data), 16'h5A);
        wr(2'd3, 8'hEE);
        check("R5", "spare write leaves A", 16'(cnt_a), 16'h3C);
        check("R5", "spare write leaves B", cnt_b, 16'h5AA5);
        rd_sel = 2'd3; #0.1 check("R5", "spare read", 16'(rd_data), 16'h0);
    endtask

    task automatic t_a_dirs();
        wr(2'd0, 8'h10);
        mode = 2'd0; pulse_a(1'b0);
        check("R2", "normal ignores dir_a", 16'(cnt_a), 16'h11);
        mode = 2'd2; pulse_a(1'b0);
        check("R2", "remote mode A up", 16'(cnt_a), 16'h12);
        mode = 2'd3; pulse_a(1'b0);
        check("R2", "spare mode A up", 16'(cnt_a), 16'h13);
        mode = 2'd1; pulse_a(1'b0); pulse_a(1'b0);
        check("R2", "track mode A down", 16'(cnt_a), 16'h11);
        pulse_a(1'b1);
        check("R2", "track mode A up", 16'(cnt_a), 16'h12);
        mode = 2'd0;
    endtask

    task automatic t_a_wrap();
        mode = 2'd0;
        wr(2'd0, 8'hFF);
        check("R7", "no flag after write", {15'b0, wrap_a}, 16'h0);
        pulse_a(1'b1);
        check("R2", "A wraps to zero", 16'(cnt_a), 16'h00);
        check("R7", "wrap_a raised", {15'b0, wrap_a}, 16'h1);
        step();
        check("R7", "wrap_a one cycle", {15'b0, wrap_a}, 16'h0);
        mode = 2'd1; pulse_a(1'b0);
        check("R7", "A down wrap value", 16'(cnt_a), 16'hFF);
        check("R7", "wrap_a on down wrap", {15'b0, wrap_a}, 16'h1);
        mode = 2'd0;
    endtask

    task automatic t_b_low();
        casc_en = 1'b0;
        wr(2'd2, 8'h12); wr(2'd1, 8'h05);
        mode = 2'd2; pulse_b(1'b1); pulse_b(1'b1); pulse_b(1'b1);
        check("R3", "remote B low down", cnt_b, 16'h1202);
        mode = 2'd1; pulse_b(1'b1);
        check("R3", "track B low up", cnt_b, 16'h1203);
        mode = 2'd3; pulse_b(1'b0);
        check("R3", "spare mode B low up", cnt_b, 16'h1204);
        mode = 2'd0;
        wr(2'd1, 8'hFF);
        pulse_b(1'b1);
        check("R4", "high byte held at 8-bit wrap", cnt_b, 16'h1200);
        check("R7", "wrap_b at 8-bit wrap", {15'b0, wrap_b}, 16'h1);
        step();
        check("R7", "wrap_b clears", {15'b0, wrap_b}, 16'h0);
    endtask

    task automatic t_b_cascade();
        casc_en = 1'b1; mode = 2'd0;
        wr(2'd2, 8'h00); wr(2'd1, 8'hFF);
        pulse_b(1'b1);
        check("R8", "carry into high", cnt_b, 16'h0100);
        check("R7", "no flag at inner boundary", {15'b0, wrap_b}, 16'h0);
        mode = 2'd2; pulse_b(1'b1);
        check("R8", "remote borrow from high", cnt_b, 16'h00FF);
        mode = 2'd1; wr(2'd2, 8'h02); wr(2'd1, 8'h00);
        pulse_b(1'b0);
        check("R8", "track down borrow", cnt_b, 16'h01FF);
        mode = 2'd0; wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
        pulse_b(1'b1);
        check("R7", "16-bit wrap value", cnt_b, 16'h0000);
        check("R7", "wrap_b at 16-bit wrap", {15'b0, wrap_b}, 16'h1);
        casc_en = 1'b0;
    endtask

    task automatic t_priority();
        mode = 2'd0;
        wr(2'd0, 8'h40);
        cnt_a_pulse = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h77;
        step();
        cnt_a_pulse = 1'b0; wr_en = 1'b0;
        check("R6", "write beats A pulse", 16'(cnt_a), 16'h77);
        wr(2'd1, 8'h20);
        cnt_b_pulse = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h90;
        step();
        cnt_b_pulse = 1'b0; wr_en = 1'b0;
        check("R6", "write beats B low pulse", 16'(cnt_b[7:0]), 16'h90);
    endtask

    task automatic t_mid_reset();
        wr(2'd0, 8'hAB); wr(2'd1, 8'hCD);
        rst_n = 1'b0;
        #1;
        check("R1", "async clear A", 16'(cnt_a), 16'h0);
        check("R1", "async clear B", cnt_b, 16'h0);
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        mode = 2'd0; casc_en = 1'b0; cnt_a_pulse = 1'b0; dir_a = 1'b0;
        cnt_b_pulse = 1'b0; dir_b = 1'b0; wr_en = 1'b0; wr_sel = 2'd0;
        wr_data = 8'h00; rd_sel = 2'd0;
        t_reset();
        t_regs();
        t_a_dirs();
        t_a_wrap();
        t_b_low();
        t_b_cascade();
        t_priority();
        t_mid_reset();
        finish_run();
    end
endmodule